// File: doc/BRIEF.md
# Quality-of-Service Output Link Arbiter

This block sits at one output port of a mesh network-on-chip router. Several input virtual channels compete for the port, and the port's link carries a small set of downstream virtual channels. The input virtual channels belong to one of two service classes. The low-numbered inputs are guaranteed-throughput and the rest are best-effort. The downstream channels are split the same way: the low-numbered ones are reserved for the guaranteed class and the rest serve best-effort traffic.

In a single combinational step each cycle, the arbiter decodes the two type bits of every waiting flit and gives a free downstream channel to a waiting header. It then picks one flit to send on the link. The guaranteed class always wins over the best-effort class, and rotation decides within a class. A downstream channel stays bound to its packet from the header until the tail has gone out. A guaranteed header may borrow an idle best-effort channel when every guaranteed channel is taken. A flit only leaves when its downstream channel holds a credit. Credits come back one per pulse on the credit return lines.

Top module: `qos_vc_out_arb`

## Requirements
- R1: The two most significant bits of a flit give its kind: 2'b11 is a header, 2'b10 is body data, 2'b00 is a tail, and 2'b01 is handled exactly like body data.
- R2: A forwarded header binds its input to one downstream channel. Every later flit of that input leaves on the same channel. The channel becomes free in the cycle after the tail is forwarded.
- R3: A bound channel is never given to another input before its tail has gone, even if a guaranteed header is left waiting. A header finding no free channel is not accepted, while other inputs keep being served.
- R4: Inputs 0 to NUM_IN_GT-1 are guaranteed and the others are best-effort. While any guaranteed input can send, no best-effort flit is forwarded.
- R5: Within a class, the search for the next grant starts at the input after the last one granted in that class. After reset the search starts at input 0.
- R6: A guaranteed header takes the lowest-numbered free channel with credit, and channels 0 to NUM_GT_VC-1 come before the rest. A best-effort header takes only channels NUM_GT_VC and above, lowest-numbered first.
- R7: Each downstream channel starts with CREDITS credits. Each forwarded flit uses one credit. Each credit_i pulse restores one credit, visible from the next cycle. A flit whose channel has no credit is not forwarded.
- R8: in_ready_o is combinational in the current cycle. A flit accepted for forwarding appears on out_valid_o, out_vc_o and out_flit_o (kind and data unchanged) after the next clock edge. out_valid_o is low after any cycle with no forwarding.
- R9: A body or tail flit on an input with no bound channel is discarded: in_ready_o rises for it, nothing is sent and no channel is bound.
- R10: After reset, out_valid_o is low, all channels are free with full credit, and with no valid input every in_ready_o bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | NUM_IN | Flit waiting on each input channel |
| in_flit_i | input | NUM_IN*(DATA_W+2) | Flits packed per input, kind in the top two bits of each |
| in_ready_o | output | NUM_IN | Flit taken this cycle (forwarded or discarded) |
| credit_i | input | NUM_VC | One credit returned per pulse, per downstream channel |
| out_valid_o | output | 1 | Flit on the link this cycle |
| out_vc_o | output | clog2(NUM_VC) | Downstream channel of the link flit |
| out_flit_o | output | DATA_W+2 | Link flit |

## Verification
Every cycle, the assertions check the following: class priority, at most one grant, credit bounds, that a granted flit has credit, the one-cycle output timing, that no two inputs share a channel, that a binding stays stable until its tail, and that best-effort headers never land on a reserved channel. Some behaviour only the directed scenarios can show. These are the exact channel numbers chosen, borrowing of a best-effort channel by the guaranteed class, the order of grants within a class, a blocked header left waiting while others proceed, reuse of a freed channel, and discarding of orphan body and tail flits.

// File: rtl/qos_arb_pkg.sv
`timescale 1ns/1ps
package qos_arb_pkg;
  typedef enum logic [1:0] {
    FK_TAIL = 2'b00,
    FK_ODD  = 2'b01,
    FK_BODY = 2'b10,
    FK_HEAD = 2'b11
  } flit_kind_e;
endpackage

// File: rtl/qos_rr_pick.sv
`timescale 1ns/1ps
module qos_rr_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // search starts one past the last grant
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    any_o   = 1'b0;
    for (int off = 1; off <= N; off++) begin
      int c;
      c = (int'(last_i) + off) % N;
      if (!any_o && req_i[c]) begin
        any_o      = 1'b1;
        grant_o[c] = 1'b1;
        idx_o      = IW'(c);
      end
    end
  end
endmodule

// File: rtl/qos_vc_select.sv
`timescale 1ns/1ps
module qos_vc_select #(
  parameter int NUM_VC    = 3,
  parameter int NUM_GT_VC = 1,
  parameter bit GT_CLASS  = 1'b0,
  localparam int VW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic [NUM_VC-1:0] free_i,
  output logic              found_o,
  output logic [VW-1:0]     vc_o
);
  // guaranteed class scans reserved channels first, best-effort skips them
  localparam int FIRST = GT_CLASS ? 0 : NUM_GT_VC;

  always_comb begin
    found_o = 1'b0;
    vc_o    = '0;
    for (int v = FIRST; v < NUM_VC; v++) begin
      if (!found_o && free_i[v]) begin
        found_o = 1'b1;
        vc_o    = VW'(v);
      end
    end
  end
endmodule

// File: rtl/qos_credit_bank.sv
`timescale 1ns/1ps
module qos_credit_bank #(
  parameter int NUM_VC  = 3,
  parameter int CREDITS = 4,
  localparam int CW = $clog2(CREDITS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_VC-1:0]    take_i,
  input  logic [NUM_VC-1:0]    ret_i,
  output logic [NUM_VC-1:0]    avail_o,
  output logic [NUM_VC*CW-1:0] cnt_o
);
  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= CW'(CREDITS);
      end else begin
        unique case ({take_i[v], ret_i[v]})
          2'b10:   cnt_q <= cnt_q - 1'b1;
          2'b01:   if (cnt_q < CW'(CREDITS)) cnt_q <= cnt_q + 1'b1;
          default: cnt_q <= cnt_q;
        endcase
      end
    end

    assign avail_o[v]           = (cnt_q != '0);
    assign cnt_o[v*CW +: CW]    = cnt_q;
  end
endmodule

// File: rtl/qos_vc_out_arb.sv
`timescale 1ns/1ps
module qos_vc_out_arb #(
  parameter int NUM_IN    = 4,
  parameter int NUM_IN_GT = 2,
  parameter int NUM_VC    = 3,
  parameter int NUM_GT_VC = 1,
  parameter int DATA_W    = 16,
  parameter int CREDITS   = 4,
  localparam int FLIT_W = DATA_W + 2,
  localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int IN_W   = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int CW     = $clog2(CREDITS + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_IN-1:0]        in_valid_i,
  input  logic [NUM_IN*FLIT_W-1:0] in_flit_i,
  output logic [NUM_IN-1:0]        in_ready_o,
  input  logic [NUM_VC-1:0]        credit_i,
  output logic                     out_valid_o,
  output logic [VC_W-1:0]          out_vc_o,
  output logic [FLIT_W-1:0]        out_flit_o
);
  import qos_arb_pkg::*;

  localparam logic [NUM_IN-1:0] GT_MASK = NUM_IN'((1 << NUM_IN_GT) - 1);

  logic [NUM_IN-1:0]      held_q;
  logic [VC_W-1:0]        hvc_q [NUM_IN];
  logic [NUM_VC-1:0]      busy_q;
  logic [IN_W-1:0]        rr_gt_q, rr_be_q;

  logic [NUM_VC-1:0]      vc_avail, vc_free, take;
  logic [NUM_VC*CW-1:0]   cred_cnt;
  logic [1:0]             kind [NUM_IN];
  logic [NUM_IN-1:0]      sel_found;
  logic [VC_W-1:0]        sel_vc [NUM_IN];
  logic [VC_W-1:0]        tgt_vc [NUM_IN];
  logic [NUM_IN-1:0]      elig, drop, fwd;
  logic [NUM_IN-1:0]      g_gt, g_be;
  logic [IN_W-1:0]        i_gt, i_be, win_idx;
  logic                   any_gt, any_be, fwd_any;
  logic [VC_W-1:0]        win_vc;
  logic [1:0]             win_kind;
  logic [NUM_IN*VC_W-1:0] hvc_flat;

  assign vc_free = ~busy_q & vc_avail;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    qos_vc_select #(
      .NUM_VC   (NUM_VC),
      .NUM_GT_VC(NUM_GT_VC),
      .GT_CLASS (i < NUM_IN_GT)
    ) u_sel (
      .free_i (vc_free),
      .found_o(sel_found[i]),
      .vc_o   (sel_vc[i])
    );
    assign hvc_flat[i*VC_W +: VC_W] = hvc_q[i];
  end

  // decode and eligibility
  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      logic hdr;
      kind[i]   = in_flit_i[i*FLIT_W + DATA_W +: 2];
      hdr       = (kind[i] == FK_HEAD);
      tgt_vc[i] = held_q[i] ? hvc_q[i] : sel_vc[i];
      elig[i]   = in_valid_i[i] &&
                  (held_q[i] ? vc_avail[hvc_q[i]] : (hdr && sel_found[i]));
      drop[i]   = in_valid_i[i] && !held_q[i] && !hdr;
    end
  end

  qos_rr_pick #(.N(NUM_IN)) u_rr_gt (
    .req_i  (elig & GT_MASK),
    .last_i (rr_gt_q),
    .grant_o(g_gt),
    .idx_o  (i_gt),
    .any_o  (any_gt)
  );

  qos_rr_pick #(.N(NUM_IN)) u_rr_be (
    .req_i  (elig & ~GT_MASK),
    .last_i (rr_be_q),
    .grant_o(g_be),
    .idx_o  (i_be),
    .any_o  (any_be)
  );

  // strict class priority
  always_comb begin
    fwd     = any_gt ? g_gt : (any_be ? g_be : '0);
    win_idx = any_gt ? i_gt : i_be;
    fwd_any = any_gt || any_be;
    win_vc  = tgt_vc[win_idx];
    win_kind = kind[win_idx];
    take    = fwd_any ? (NUM_VC'(1) << win_vc) : '0;
  end

  assign in_ready_o = fwd | drop;

  qos_credit_bank #(
    .NUM_VC (NUM_VC),
    .CREDITS(CREDITS)
  ) u_cred (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .ret_i  (credit_i),
    .avail_o(vc_avail),
    .cnt_o  (cred_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q      <= '0;
      busy_q      <= '0;
      rr_gt_q     <= IN_W'(NUM_IN - 1);
      rr_be_q     <= IN_W'(NUM_IN - 1);
      out_valid_o <= 1'b0;
      out_vc_o    <= '0;
      out_flit_o  <= '0;
      for (int i = 0; i < NUM_IN; i++) hvc_q[i] <= '0;
    end else begin
      out_valid_o <= fwd_any;
      if (fwd_any) begin
        out_vc_o   <= win_vc;
        out_flit_o <= in_flit_i[win_idx*FLIT_W +: FLIT_W];
        if (!held_q[win_idx]) begin
          held_q[win_idx] <= 1'b1;
          hvc_q[win_idx]  <= win_vc;
          busy_q[win_vc]  <= 1'b1;
        end else if (win_kind == FK_TAIL) begin
          held_q[win_idx] <= 1'b0;
          busy_q[win_vc]  <= 1'b0;
        end
        if (any_gt) rr_gt_q <= win_idx;
        else        rr_be_q <= win_idx;
      end
    end
  end
endmodule

// File: rtl/qos_vc_out_arb_chk.sv
`timescale 1ns/1ps
module qos_vc_out_arb_chk #(
  parameter int NUM_IN    = 4,
  parameter int NUM_IN_GT = 2,
  parameter int NUM_VC    = 3,
  parameter int NUM_GT_VC = 1,
  parameter int CREDITS   = 4,
  localparam int VC_W = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int CW   = $clog2(CREDITS + 1)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_IN-1:0]        fwd_i,
  input logic [NUM_IN-1:0]        elig_i,
  input logic [VC_W-1:0]          win_vc_i,
  input logic [1:0]               win_kind_i,
  input logic [NUM_IN-1:0]        held_i,
  input logic [NUM_IN*VC_W-1:0]   hvc_i,
  input logic [NUM_VC*CW-1:0]     cnt_i,
  input logic                     out_valid_i
);
  localparam logic [NUM_IN-1:0] GT_MASK = NUM_IN'((1 << NUM_IN_GT) - 1);

  logic [CW-1:0] win_cnt;
  logic          share;

  always_comb begin
    win_cnt = '0;
    for (int v = 0; v < NUM_VC; v++)
      if (win_vc_i == VC_W'(v)) win_cnt = cnt_i[v*CW +: CW];
    share = 1'b0;
    for (int i = 0; i < NUM_IN; i++)
      for (int j = i + 1; j < NUM_IN; j++)
        if (held_i[i] && held_i[j] &&
            hvc_i[i*VC_W +: VC_W] == hvc_i[j*VC_W +: VC_W]) share = 1'b1;
  end

  p_gt_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(elig_i & GT_MASK)) |-> ((fwd_i & ~GT_MASK) == '0));

  p_one_grant_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fwd_i));

  p_out_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fwd_i) |=> out_valid_i);

  p_out_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|fwd_i) |=> !out_valid_i);

  p_send_credit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fwd_i) |-> (win_cnt != '0));

  p_no_share_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !share);

  p_be_head_vc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(fwd_i & ~GT_MASK)) && win_kind_i == 2'b11) |-> (win_vc_i >= VC_W'(NUM_GT_VC)));

  for (genvar v = 0; v < NUM_VC; v++) begin : g_cv
    p_credit_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_i[v*CW +: CW] <= CW'(CREDITS));
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_ci
    p_bind_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (held_i[i] && !(fwd_i[i] && win_kind_i == 2'b00))
        |=> (held_i[i] && $stable(hvc_i[i*VC_W +: VC_W])));
  end
endmodule

bind qos_vc_out_arb qos_vc_out_arb_chk #(
  .NUM_IN   (NUM_IN),
  .NUM_IN_GT(NUM_IN_GT),
  .NUM_VC   (NUM_VC),
  .NUM_GT_VC(NUM_GT_VC),
  .CREDITS  (CREDITS)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fwd_i      (fwd),
  .elig_i     (elig),
  .win_vc_i   (win_vc),
  .win_kind_i (win_kind),
  .held_i     (held_q),
  .hvc_i      (hvc_flat),
  .cnt_i      (cred_cnt),
  .out_valid_i(out_valid_o)
);

// File: tb/qos_vc_out_arb_tb_top.sv
`timescale 1ns/1ps
module qos_vc_out_arb_tb_top;
  localparam int NIN = 4;
  localparam int NVC = 3;
  localparam int DW  = 16;
  localparam int FW  = DW + 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NIN-1:0]    in_valid = '0;
  logic [NIN*FW-1:0] in_flit = '0;
  logic [NIN-1:0]    in_ready;
  logic [NVC-1:0]    credit = '0;
  logic              out_valid;
  logic [1:0]        out_vc;
  logic [FW-1:0]     out_flit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  qos_vc_out_arb dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid),
    .in_flit_i  (in_flit),
    .in_ready_o (in_ready),
    .credit_i   (credit),
    .out_valid_o(out_valid),
    .out_vc_o   (out_vc),
    .out_flit_o (out_flit)
  );

  localparam logic [1:0] HD = 2'b11, BD = 2'b10, TL = 2'b00, OD = 2'b01;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic put(int i, logic v, logic [1:0] k, logic [15:0] d);
    in_valid[i] = v;
    in_flit[i*FW +: FW] = {k, d};
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    in_valid = '0;
    in_flit = '0;
    credit = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    do_reset();
    #2;
    chk("R10 ready idle", in_ready, 0);
    chk("R10 out_valid", out_valid, 0);
    cyc();
    chk("R10 out_valid later", out_valid, 0);
  endtask

  task automatic t_single();
    do_reset();
    put(0, 1, HD, 16'h00A1); #2;
    chk("R2 head ready", in_ready, 4'b0001);
    cyc();
    chk("R8 out_valid", out_valid, 1);
    chk("R6 gt vc", out_vc, 0);
    chk("R1 head flit", out_flit, {HD, 16'h00A1});
    put(0, 1, BD, 16'h00A2); cyc();
    chk("R2 body vc", out_vc, 0);
    chk("R1 body flit", out_flit, {BD, 16'h00A2});
    put(0, 1, TL, 16'h00A3); cyc();
    chk("R1 tail flit", out_flit, {TL, 16'h00A3});
    put(0, 0, TL, 0); #2;
    chk("R8 no ready", in_ready, 0);
    cyc();
    chk("R8 idle out", out_valid, 0);
    put(1, 1, HD, 16'h00B1); cyc();
    chk("R2 freed vc reused", out_vc, 0);
    put(1, 0, TL, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    put(0, 1, HD, 1); cyc();
    chk("R6 first gt vc", out_vc, 0);
    put(0, 0, BD, 0); put(1, 1, HD, 2); cyc();
    chk("R6 gt borrows be", out_vc, 1);
    put(1, 0, BD, 0); put(2, 1, HD, 3); cyc();
    chk("R6 be next vc", out_vc, 2);
    put(2, 0, BD, 0); put(3, 1, HD, 4); #2;
    chk("R3 no free vc", in_ready, 0);
    cyc();
    chk("R3 nothing out", out_valid, 0);
    put(3, 0, BD, 0);
  endtask

  task automatic t_priority();
    do_reset();
    put(0, 1, HD, 5); put(2, 1, HD, 6); #2;
    chk("R4 gt wins", in_ready, 4'b0001);
    cyc();
    chk("R4 gt vc", out_vc, 0);
    put(0, 0, BD, 0); #2;
    chk("R4 be after", in_ready, 4'b0100);
    cyc();
    chk("R6 be vc", out_vc, 1);
    chk("R4 be flit", out_flit, {HD, 16'h0006});
    put(2, 0, BD, 0);
  endtask

  task automatic t_no_preempt();
    do_reset();
    put(0, 1, HD, 1); cyc(); put(0, 0, BD, 0);
    put(2, 1, HD, 2); cyc(); put(2, 0, BD, 0);
    put(3, 1, HD, 3); cyc(); put(3, 0, BD, 0);
    put(1, 1, HD, 4); put(2, 1, BD, 5); #2;
    chk("R3 gt blocked be sends", in_ready, 4'b0100);
    cyc();
    chk("R3 be keeps vc", out_vc, 1);
    put(2, 1, TL, 6); #2;
    chk("R3 tail proceeds", in_ready, 4'b0100);
    cyc();
    chk("R3 tail vc", out_vc, 1);
    put(2, 0, BD, 0); #2;
    chk("R3 gt gets freed", in_ready, 4'b0010);
    cyc();
    chk("R3 freed vc to gt", out_vc, 1);
    put(1, 0, BD, 0);
  endtask

  task automatic t_rr();
    do_reset();
    put(0, 1, HD, 1); cyc(); put(0, 0, BD, 0);
    put(1, 1, HD, 2); cyc();
    put(0, 1, BD, 3); put(1, 1, BD, 4); #2;
    chk("R5 gt turn 0", in_ready, 4'b0001);
    cyc(); #2;
    chk("R5 gt turn 1", in_ready, 4'b0010);
    cyc();
    chk("R5 gt out vc", out_vc, 1);
    do_reset();
    put(2, 1, HD, 7); put(3, 1, HD, 8); #2;
    chk("R5 be starts low", in_ready, 4'b0100);
    cyc(); #2;
    chk("R5 be rotates", in_ready, 4'b1000);
    cyc();
    chk("R5 be second vc", out_vc, 2);
    put(2, 0, BD, 0); put(3, 0, BD, 0);
  endtask

  task automatic t_credit();
    do_reset();
    put(2, 1, HD, 1); cyc();
    for (int k = 0; k < 3; k++) begin
      put(2, 1, BD, 16'(k + 2)); cyc();
      chk("R7 credit used", out_valid, 1);
    end
    #2;
    chk("R7 empty blocks", in_ready, 0);
    cyc();
    chk("R7 no send", out_valid, 0);
    credit[1] = 1'b1; #2;
    chk("R7 return next cycle", in_ready, 0);
    cyc();
    credit[1] = 1'b0; #2;
    chk("R7 returned credit", in_ready, 4'b0100);
    cyc();
    chk("R7 sent on vc", out_vc, 1);
    #2;
    chk("R7 drained again", in_ready, 0);
    put(2, 0, BD, 0);
  endtask

  task automatic t_discard();
    do_reset();
    put(3, 1, BD, 9); #2;
    chk("R9 body dropped", in_ready, 4'b1000);
    cyc();
    chk("R9 nothing sent", out_valid, 0);
    put(3, 1, TL, 10); #2;
    chk("R9 tail dropped", in_ready, 4'b1000);
    cyc();
    chk("R9 nothing sent tail", out_valid, 0);
    put(3, 1, HD, 11); cyc();
    chk("R9 vc still free", out_vc, 1);
    put(3, 1, OD, 12); cyc();
    chk("R1 odd as body", out_flit, {OD, 16'h000C});
    put(3, 1, BD, 13); cyc();
    chk("R1 odd keeps bind", out_vc, 1);
    chk("R1 body after odd", out_valid, 1);
    put(3, 0, BD, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_overflow();
    t_priority();
    t_no_preempt();
    t_rr();
    t_credit();
    t_discard();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule